// File: doc/BRIEF.md
# Dual-Port Sample Demultiplexer with Sync

This block is the digital back end of a fast sampling converter and runs entirely in the sample-clock domain. Each cycle it takes one 10-bit conversion code in offset binary, with separate flags for input above full scale and input below full scale. It clamps and recodes the sample, then pushes it through a fixed-length pipeline. Successive samples go to two half-rate output ports, A and B, and a half-rate data clock is produced that lines up with the port transitions.

A mode pin chooses staggered port updates, where the ports update on alternate edges, or aligned updates, where port A passes through one extra stage so that both ports change on the same edge. A format pin chooses offset binary or two's complement output. An active-high sync input holds every output still, discards samples already in flight, and fixes which port receives the next sample.

The port steering is kept by a three-state route machine. RT_TO_B means the next captured sample goes to B, and RT_TO_A means it goes to A. RT_HOLD is the state while sync is high. The transitions are RT_TO_B to RT_TO_A on a capture, RT_TO_A to RT_TO_B on a capture, RT_HOLD to RT_TO_A on the first capture after sync drops (that sample goes to B), and any state to RT_HOLD while sync is high. Reset enters RT_TO_B.

Top module: `dmx_demux`

## Requirements
- R1: While `rst` is high (synchronous, active high), the registered outputs clear: both ports and both over-range bits go to zero, `dclk_out` goes low, and in-flight samples are dropped. The first sample captured after reset goes to port B.
- R2: Samples captured on consecutive edges go to alternate ports in the order B, A, B, A.
- R3: With `ilv_mode` = 1 (staggered), a sample captured at edge N appears on its port right after edge N+6, whichever port it goes to.
- R4: With `ilv_mode` = 0 (aligned), port B shows its sample right after edge N+6 and port A right after edge N+7, so both ports change on the same edge.
- R5: `dclk_out` goes high on the edge where port B takes a new sample and goes low on the edge where the following A sample leaves the pipeline. It holds its value when no sample arrives.
- R6: At every edge where `sync_hold` is 1, neither port, neither over-range bit and `dclk_out` changes. Samples already in the pipeline are discarded and never reach a port.
- R7: When `sync_hold` is 0 at edge N after being 1, sample N goes to port B and sample N+1 goes to port A.
- R8: `fmt_twos` = 1 selects two's complement, which is the offset-binary code with bit DW-1 inverted. `fmt_twos` = 0 selects offset binary. The format is sampled together with each sample.
- R9: A sample with `smp_hi` = 1 gives the maximum code with its over-range bit set: 0x3FF in offset binary, 0x1FF in two's complement. `smp_hi` takes priority over `smp_lo`.
- R10: A sample with `smp_lo` = 1 (and `smp_hi` = 0) gives the minimum code with its over-range bit set: 0x000 in offset binary, 0x200 in two's complement.
- R11: A sample with neither flag set gives its input code, recoded as selected, with the port's over-range bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_code | input | DW | Conversion code, offset binary |
| smp_hi | input | 1 | Input above positive full scale |
| smp_lo | input | 1 | Input below negative full scale |
| fmt_twos | input | 1 | 1 = two's complement output, 0 = offset binary |
| ilv_mode | input | 1 | 1 = staggered updates, 0 = aligned updates |
| sync_hold | input | 1 | Freeze outputs and resynchronise port assignment |
| a_data | output | DW | Port A sample |
| a_ovr | output | 1 | Port A over-range |
| b_data | output | DW | Port B sample |
| b_ovr | output | 1 | Port B over-range |
| dclk_out | output | 1 | Half-rate data clock |

## Verification
The hardest case to reach is a sync pulse that lands while samples are in flight and while the route machine expects port A next. Only then do the discard of pending samples, the forced return to port B and a held-high data clock all show at once. The stimulus runs a stream of distinct codes for an odd number of edges, raises sync for several edges, and then restarts with a fresh code sequence. At every edge until the first new sample emerges, the bench checks that the outputs still hold exactly the values they had before sync.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [1:0] {
        RT_TO_B = 2'd0,
        RT_TO_A = 2'd1,
        RT_HOLD = 2'd2
    } route_st_e;

    typedef struct packed {
        logic vld;
        logic to_a;
        logic ovr;
    } smp_tag_t;

endpackage

// File: rtl/dmx_code_fmt.sv
module dmx_code_fmt #(
    parameter int unsigned DW = 10
) (
    input  logic [DW-1:0] raw,
    input  logic          over_hi,
    input  logic          under_lo,
    input  logic          twos,
    output logic [DW-1:0] code,
    output logic          ovr
);
    localparam logic [DW-1:0] CODE_TOP = {DW{1'b1}};
    localparam logic [DW-1:0] CODE_BOT = {DW{1'b0}};
    localparam logic [DW-1:0] MSB_FLIP = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] clamped;

    always_comb begin
        if (over_hi) begin
            clamped = CODE_TOP;
        end else if (under_lo) begin
            clamped = CODE_BOT;
        end else begin
            clamped = raw;
        end
        ovr  = over_hi | under_lo;
        code = twos ? (clamped ^ MSB_FLIP) : clamped;
    end
endmodule

// File: rtl/dmx_route_fsm.sv
module dmx_route_fsm
    import dmx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_hold,
    output logic cap_vld,
    output logic cap_to_a
);
    route_st_e state_q;
    route_st_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RT_TO_B;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (sync_hold) begin
            state_d = RT_HOLD;
        end else begin
            unique case (state_q)
                RT_TO_B: state_d = RT_TO_A;
                RT_TO_A: state_d = RT_TO_B;
                RT_HOLD: state_d = RT_TO_A;
                default: state_d = RT_TO_B;
            endcase
        end
    end

    always_comb begin
        cap_vld = ~sync_hold;
        unique case (state_q)
            RT_TO_A: cap_to_a = 1'b1;
            RT_TO_B: cap_to_a = 1'b0;
            RT_HOLD: cap_to_a = 1'b0;
            default: cap_to_a = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmx_lat_pipe.sv
module dmx_lat_pipe
    import dmx_pkg::*;
#(
    parameter int unsigned DW    = 10,
    parameter int unsigned DEPTH = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [DW-1:0] in_dat,
    input  smp_tag_t      in_tag,
    output logic [DW-1:0] main_dat,
    output smp_tag_t      main_tag,
    output logic [DW-1:0] late_dat,
    output smp_tag_t      late_tag
);
    localparam int unsigned MAIN_IX = DEPTH - 2;
    localparam int unsigned LATE_IX = DEPTH - 1;

    logic [DW-1:0] dat_q [DEPTH];
    smp_tag_t      tag_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) begin
                dat_q[s] <= '0;
                tag_q[s] <= '0;
            end
        end else begin
            dat_q[0] <= in_dat;
            tag_q[0] <= in_tag;
            for (int s = 1; s < DEPTH; s++) begin
                dat_q[s] <= dat_q[s-1];
                if (flush) begin
                    tag_q[s] <= '0;
                end else begin
                    tag_q[s] <= tag_q[s-1];
                end
            end
        end
    end

    assign main_dat = dat_q[MAIN_IX];
    assign main_tag = tag_q[MAIN_IX];
    assign late_dat = dat_q[LATE_IX];
    assign late_tag = tag_q[LATE_IX];
endmodule

// File: rtl/dmx_port_out.sv
module dmx_port_out
    import dmx_pkg::*;
#(
    parameter int unsigned DW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          freeze,
    input  logic          ilv,
    input  logic [DW-1:0] main_dat,
    input  smp_tag_t      main_tag,
    input  logic [DW-1:0] late_dat,
    input  smp_tag_t      late_tag,
    output logic [DW-1:0] a_q,
    output logic          a_ovr_q,
    output logic [DW-1:0] b_q,
    output logic          b_ovr_q,
    output logic          dclk_q
);
    logic          ld_a;
    logic          ld_b;
    logic [DW-1:0] a_src;
    logic          a_src_ovr;

    always_comb begin
        ld_b = ~freeze & main_tag.vld & ~main_tag.to_a;
        if (ilv) begin
            ld_a      = ~freeze & main_tag.vld & main_tag.to_a;
            a_src     = main_dat;
            a_src_ovr = main_tag.ovr;
        end else begin
            ld_a      = ~freeze & late_tag.vld & late_tag.to_a;
            a_src     = late_dat;
            a_src_ovr = late_tag.ovr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            a_ovr_q <= 1'b0;
            b_q     <= '0;
            b_ovr_q <= 1'b0;
            dclk_q  <= 1'b0;
        end else begin
            if (ld_a) begin
                a_q     <= a_src;
                a_ovr_q <= a_src_ovr;
            end
            if (ld_b) begin
                b_q     <= main_dat;
                b_ovr_q <= main_tag.ovr;
            end
            if (!freeze && main_tag.vld) begin
                dclk_q <= ~main_tag.to_a;
            end
        end
    end
endmodule

// File: rtl/dmx_demux.sv
module dmx_demux
    import dmx_pkg::*;
#(
    parameter int unsigned DW      = 10,
    parameter int unsigned LAT_ILV = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] smp_code,
    input  logic          smp_hi,
    input  logic          smp_lo,
    input  logic          fmt_twos,
    input  logic          ilv_mode,
    input  logic          sync_hold,
    output logic [DW-1:0] a_data,
    output logic          a_ovr,
    output logic [DW-1:0] b_data,
    output logic          b_ovr,
    output logic          dclk_out
);
    localparam int unsigned DEPTH = LAT_ILV + 1;

    logic [DW-1:0] fmt_code;
    logic          fmt_ovr;
    logic          cap_vld;
    logic          cap_to_a;
    smp_tag_t      cap_tag;
    logic [DW-1:0] main_dat;
    smp_tag_t      main_tag;
    logic [DW-1:0] late_dat;
    smp_tag_t      late_tag;

    dmx_code_fmt #(.DW(DW)) u_fmt (
        .raw      (smp_code),
        .over_hi  (smp_hi),
        .under_lo (smp_lo),
        .twos     (fmt_twos),
        .code     (fmt_code),
        .ovr      (fmt_ovr)
    );

    dmx_route_fsm u_route (
        .clk       (clk),
        .rst       (rst),
        .sync_hold (sync_hold),
        .cap_vld   (cap_vld),
        .cap_to_a  (cap_to_a)
    );

    always_comb begin
        cap_tag.vld  = cap_vld;
        cap_tag.to_a = cap_to_a;
        cap_tag.ovr  = fmt_ovr;
    end

    dmx_lat_pipe #(.DW(DW), .DEPTH(DEPTH)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .flush    (sync_hold),
        .in_dat   (fmt_code),
        .in_tag   (cap_tag),
        .main_dat (main_dat),
        .main_tag (main_tag),
        .late_dat (late_dat),
        .late_tag (late_tag)
    );

    dmx_port_out #(.DW(DW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .freeze   (sync_hold),
        .ilv      (ilv_mode),
        .main_dat (main_dat),
        .main_tag (main_tag),
        .late_dat (late_dat),
        .late_tag (late_tag),
        .a_q      (a_data),
        .a_ovr_q  (a_ovr),
        .b_q      (b_data),
        .b_ovr_q  (b_ovr),
        .dclk_q   (dclk_out)
    );
endmodule

// File: rtl/dmx_demux_chk.sv
module dmx_demux_chk #(
    parameter int unsigned DW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          ilv_mode,
    input logic          sync_hold,
    input logic [DW-1:0] a_data,
    input logic          a_ovr,
    input logic [DW-1:0] b_data,
    input logic          b_ovr,
    input logic          dclk_out
);
    localparam logic [DW-1:0] K_ONES = {DW{1'b1}};
    localparam logic [DW-1:0] K_ZERO = {DW{1'b0}};
    localparam logic [DW-1:0] K_PMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] K_NMIN = {1'b1, {(DW-1){1'b0}}};

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (a_data == K_ZERO && b_data == K_ZERO && !a_ovr && !b_ovr && !dclk_out));

    a_r6_freeze_hold: assert property (@(posedge clk) disable iff (rst)
        sync_hold |=> ($stable(a_data) && $stable(b_data) && $stable(a_ovr)
                       && $stable(b_ovr) && $stable(dclk_out)));

    a_r5_b_with_dclk_high: assert property (@(posedge clk) disable iff (rst)
        !$stable(b_data) |-> dclk_out);

    a_r3_ilv_a_dclk_low: assert property (@(posedge clk) disable iff (rst)
        (ilv_mode && !$stable(a_data)) |-> !dclk_out);

    a_r4_par_a_with_b: assert property (@(posedge clk) disable iff (rst)
        (!ilv_mode && !$stable(a_data)) |-> dclk_out);

    // R9 and R10: a set over-range bit only accompanies a clamp code
    a_r9_a_ovr_code: assert property (@(posedge clk) disable iff (rst)
        a_ovr |-> (a_data == K_ONES || a_data == K_ZERO || a_data == K_PMAX || a_data == K_NMIN));

    a_r10_b_ovr_code: assert property (@(posedge clk) disable iff (rst)
        b_ovr |-> (b_data == K_ONES || b_data == K_ZERO || b_data == K_PMAX || b_data == K_NMIN));
endmodule

bind dmx_demux dmx_demux_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ilv_mode  (ilv_mode),
    .sync_hold (sync_hold),
    .a_data    (a_data),
    .a_ovr     (a_ovr),
    .b_data    (b_data),
    .b_ovr     (b_ovr),
    .dclk_out  (dclk_out)
);

// File: tb/dmx_demux_test.sv
`timescale 1ns/1ps
module dmx_demux_test;
    localparam int DW = 10;

    // {code[9:0], hi, lo, twos, expected[9:0], expected ovr}
    localparam logic [23:0] VEC [16] = '{
        {10'h155, 3'b000, 10'h155, 1'b0},
        {10'h2AA, 3'b000, 10'h2AA, 1'b0},
        {10'h155, 3'b001, 10'h355, 1'b0},
        {10'h2AA, 3'b001, 10'h0AA, 1'b0},
        {10'h123, 3'b100, 10'h3FF, 1'b1},
        {10'h123, 3'b101, 10'h1FF, 1'b1},
        {10'h321, 3'b010, 10'h000, 1'b1},
        {10'h321, 3'b011, 10'h200, 1'b1},
        {10'h3FF, 3'b000, 10'h3FF, 1'b0},
        {10'h000, 3'b001, 10'h200, 1'b0},
        {10'h200, 3'b000, 10'h200, 1'b0},
        {10'h200, 3'b001, 10'h000, 1'b0},
        {10'h0F0, 3'b110, 10'h3FF, 1'b1},
        {10'h0F0, 3'b111, 10'h1FF, 1'b1},
        {10'h001, 3'b001, 10'h201, 1'b0},
        {10'h1FE, 3'b000, 10'h1FE, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] smp_code = '0;
    logic          smp_hi = 1'b0;
    logic          smp_lo = 1'b0;
    logic          fmt_twos = 1'b0;
    logic          ilv_mode = 1'b1;
    logic          sync_hold = 1'b0;
    logic [DW-1:0] a_data;
    logic          a_ovr;
    logic [DW-1:0] b_data;
    logic          b_ovr;
    logic          dclk_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmx_demux #(.DW(DW), .LAT_ILV(6)) uut (
        .clk(clk), .rst(rst), .smp_code(smp_code), .smp_hi(smp_hi), .smp_lo(smp_lo),
        .fmt_twos(fmt_twos), .ilv_mode(ilv_mode), .sync_hold(sync_hold),
        .a_data(a_data), .a_ovr(a_ovr), .b_data(b_data), .b_ovr(b_ovr), .dclk_out(dclk_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string vec_req(input int i);
        if (VEC[i][13]) return "R9";
        if (VEC[i][12]) return "R10";
        if (VEC[i][11]) return "R8";
        return "R11";
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_vec(input int k);
        if (k < 16) begin
            smp_code = VEC[k][23:14];
            smp_hi   = VEC[k][13];
            smp_lo   = VEC[k][12];
            fmt_twos = VEC[k][11];
        end else begin
            smp_code = '0; smp_hi = 0; smp_lo = 0; fmt_twos = 0;
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1; sync_hold = 1'b0; ilv_mode = mode;
        step(); step();
        chk("R1", "a_data", int'(a_data), 0);
        chk("R1", "b_data", int'(b_data), 0);
        chk("R1", "ovr", int'({a_ovr, b_ovr}), 0);
        chk("R1", "dclk", int'(dclk_out), 0);
        rst = 1'b0;
    endtask

    task automatic exp_port(input logic is_a, input int i);
        string r;
        r = vec_req(i);
        if (is_a) begin
            chk(r, "a_data R2", int'(a_data), int'(VEC[i][10:1]));
            chk(r, "a_ovr", int'(a_ovr), int'(VEC[i][0]));
        end else begin
            chk(r, "b_data R2", int'(b_data), int'(VEC[i][10:1]));
            chk(r, "b_ovr", int'(b_ovr), int'(VEC[i][0]));
        end
    endtask

    initial begin
        #1;
        // staggered mode vector walk
        do_reset(1'b1);
        for (int k = 0; k < 24; k++) begin
            drive_vec(k);
            step();
            if (k == 5) begin
                chk("R3", "b early", int'(b_data), 0);
                chk("R3", "a early", int'(a_data), 0);
                chk("R5", "dclk early", int'(dclk_out), 0);
            end
            if (k >= 6 && k < 22) begin
                if (((k - 6) % 2) == 0) begin
                    exp_port(1'b0, k - 6);
                    chk("R5", "dclk at B update", int'(dclk_out), 1);
                end else begin
                    exp_port(1'b1, k - 6);
                    chk("R3", "dclk at A update", int'(dclk_out), 0);
                end
            end
        end

        // aligned mode vector walk
        do_reset(1'b0);
        for (int k = 0; k < 24; k++) begin
            drive_vec(k);
            step();
            if (k == 6) chk("R4", "a not yet", int'(a_data), 0);
            if (k == 7) begin
                chk("R4", "a held odd edge", int'(a_data), 0);
                chk("R5", "dclk low", int'(dclk_out), 0);
            end
            if ((k % 2) == 0 && k >= 6 && k < 22) begin
                exp_port(1'b0, k - 6);
                chk("R4", "dclk high", int'(dclk_out), 1);
            end
            if ((k % 2) == 0 && k >= 8 && k < 23) begin
                exp_port(1'b1, k - 7);
            end
        end

        // sync during a live stream, A expected next at assertion
        do_reset(1'b1);
        for (int k = 0; k < 22; k++) begin
            smp_hi = 0; smp_lo = 0; fmt_twos = 0;
            sync_hold = (k >= 9 && k <= 12);
            if (k < 9) smp_code = 10'(32'h100 + k);
            else if (k <= 12) smp_code = 10'h1AB;
            else smp_code = 10'(32'h080 + (k - 13));
            step();
            if (k == 8) begin
                chk("R3", "b before sync", int'(b_data), 'h102);
                chk("R3", "a before sync", int'(a_data), 'h101);
            end
            if (k >= 9 && k <= 18) begin
                chk("R6", "b frozen", int'(b_data), 'h102);
                chk("R6", "a frozen", int'(a_data), 'h101);
                chk("R6", "dclk frozen", int'(dclk_out), 1);
            end
            if (k == 19) chk("R7", "first to B", int'(b_data), 'h080);
            if (k == 20) begin
                chk("R7", "second to A", int'(a_data), 'h081);
                chk("R5", "dclk after A", int'(dclk_out), 0);
            end
        end
        sync_hold = 1'b0;

        // reset in the middle of a stream
        do_reset(1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule